// File: doc/BRIEF.md
# Relocatable Prescaled Down Timer

A 16-bit down-counting interval timer that software loads and reads through a small register access port. The count steps down once every eight system clocks. The step comes from a free-running divide-by-8 prescaler that nothing but reset clears. A write loads a new count and starts an interval. Software then polls the value until it reaches zero, where it stays.

The timer register has no fixed address. A base register, written over a separate configuration port, holds the address the timer answers at and an enable bit. An access gets a response only when its address equals the stored base and the enable is set. Counting continues whether or not access is enabled. Accesses may be 16 or 32 bits wide. Bits 31:16 of write data are dropped, and bits 31:16 of read data are zero. Because a write does not realign the prescaler, the first step after a load falls one to eight clocks later.

Top module: `reloc_down_timer`

## Requirements
- R1: With no load, the count decreases by exactly one on the 8th, 16th, 24th, ... rising clock edge after reset release. The prescaler runs freely and a write does not restart it.
- R2: A responding write loads acc_wdata_i[15:0] into the count at its capture edge. When that edge is also a step edge, the loaded value is kept unchanged.
- R3: Bits 31:16 of write data have no effect on the count. Bits 31:16 of acc_rdata_o are always zero.
- R4: An access responds only when acc_addr_i equals the stored base address (all 16 bits) and the stored enable bit is 1. acc_hit_o goes high in the cycle after a responding access.
- R5: A non-responding access leaves the count unchanged. In the following cycle it gives acc_hit_o = 0 and acc_rdata_o = 0.
- R6: The count keeps stepping while access is disabled.
- R7: A count of zero stays at zero until the next load.
- R8: After reset the count is 0, the base address is 0 with access disabled, and acc_hit_o and acc_rdata_o are 0.
- R9: A responding read returns, in the next cycle, the count as it stood just before the capture edge, in bits 15:0.
- R10: A cfg_we_i pulse replaces the base address and enable. Accesses captured at later edges use the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the base register |
| cfg_base_i | input | 16 | New base address |
| cfg_en_i | input | 1 | New access enable |
| acc_valid_i | input | 1 | Access request, one cycle |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 16 | Access address |
| acc_wdata_i | input | 32 | Write data; bits 31:16 ignored |
| acc_hit_o | output | 1 | Access responded, one cycle after request |
| acc_rdata_o | output | 32 | Read data, one cycle after request |

## Verification
Each access is captured at a rising edge. acc_hit_o and acc_rdata_o are due at the following edge, so the bench samples them at the falling edge after that. A load takes effect at its own capture edge. A read returns the count as it stood before its capture edge. The bench numbers edges from reset release and predicts each read value arithmetically as the loaded value minus the multiples of eight that lie between the load edge and the read edge, floored at zero. A sweep places a load at every prescaler phase and reads back at each offset.

// File: rtl/reloc_timer_pkg.sv
package reloc_timer_pkg;
  localparam int unsigned ADDR_W  = 16;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned PRE_DIV = 8;

  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] addr;
  } base_reg_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ph_q <= '0;
    else if (ph_q == LAST) ph_q <= '0;
    else                   ph_q <= ph_q + 1'b1;
  end

  assign tick_o = (ph_q == LAST);

  assert_tick_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/tmr_addr_match.sv
module tmr_addr_match
  import reloc_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic              cfg_en_i,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  output logic              en_o,
  output logic              sel_o
);
  base_reg_t base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       base_q <= '0;
    else if (cfg_we_i) base_q <= '{en: cfg_en_i, addr: cfg_base_i};
  end

  assign en_o  = base_q.en;
  assign sel_o = acc_valid_i && base_q.en && (acc_addr_i == base_q.addr);

  assert_cfg_take_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (en_o == $past(cfg_en_i)));
endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  // load beats tick; zero is sticky
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (tick_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
  assert_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && cnt_q != 0) |=> cnt_q == $past(cnt_q) - 1'b1);
  assert_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q));
  assert_floor_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == 0 && !load_i) |=> cnt_q == 0);
endmodule

// File: rtl/reloc_down_timer.sv
module reloc_down_timer
  import reloc_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic              cfg_en_i,
  input  logic              acc_valid_i,
  input  logic              acc_we_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [BUS_W-1:0]  acc_wdata_i,
  output logic              acc_hit_o,
  output logic [BUS_W-1:0]  acc_rdata_o
);
  logic             tick, sel, en;
  logic [CNT_W-1:0] cnt;
  logic             unused_hi;
  logic             hit_q;
  logic [BUS_W-1:0] rdata_q;

  assign unused_hi = ^acc_wdata_i[BUS_W-1:CNT_W];

  tmr_prescaler #(.DIV(PRE_DIV)) i_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  tmr_addr_match i_match (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_base_i  (cfg_base_i),
    .cfg_en_i    (cfg_en_i),
    .acc_valid_i (acc_valid_i),
    .acc_addr_i  (acc_addr_i),
    .en_o        (en),
    .sel_o       (sel)
  );

  tmr_down_counter #(.W(CNT_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .load_i     (sel && acc_we_i),
    .load_val_i (acc_wdata_i[CNT_W-1:0]),
    .cnt_o      (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      hit_q   <= sel;
      rdata_q <= (sel && !acc_we_i) ? {{(BUS_W-CNT_W){1'b0}}, cnt} : '0;
    end
  end

  assign acc_hit_o   = hit_q;
  assign acc_rdata_o = rdata_q;

  assert_hit_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_hit_o |-> $past(acc_valid_i));
  assert_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !en) |=> (!acc_hit_o && acc_rdata_o == '0));
  assert_rd_val_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && !acc_we_i) |=> acc_rdata_o[CNT_W-1:0] == $past(cnt));
endmodule

// File: tb/test_reloc_down_timer.sv
module test_reloc_down_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0, cfg_en_i = 1'b0;
  logic [15:0] cfg_base_i = '0;
  logic        acc_valid_i = 1'b0, acc_we_i = 1'b0;
  logic [15:0] acc_addr_i = '0;
  logic [31:0] acc_wdata_i = '0;
  logic        acc_hit_o;
  logic [31:0] acc_rdata_o;

  int n_chk = 0, n_bad = 0;
  int edge_n = 0;
  int ld_edge = 0, ld_val = 0;
  bit done = 1'b0;

  reloc_down_timer i_reloc_down_timer (.*);

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) if (rst_ni) edge_n <= edge_n + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // value seen by a read captured at edge r
  function automatic int expv(input int r);
    int t;
    t = (r - 1) / 8 - ld_edge / 8;
    return (ld_val > t) ? ld_val - t : 0;
  endfunction

  task automatic cfg(input logic [15:0] b, input logic e);
    @(negedge clk_i); cfg_we_i = 1; cfg_base_i = b; cfg_en_i = e;
    @(negedge clk_i); cfg_we_i = 0;
  endtask

  task automatic acc(input bit we, input logic [15:0] a, input logic [31:0] d,
                     output int cap, output logic hit, output logic [31:0] rd);
    @(negedge clk_i);
    acc_valid_i = 1; acc_we_i = we; acc_addr_i = a; acc_wdata_i = d; cap = edge_n + 1;
    @(negedge clk_i);
    acc_valid_i = 0; acc_we_i = 0;
    hit = acc_hit_o; rd = acc_rdata_o;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input bit expect_hit, input string tag);
    int c; logic h; logic [31:0] r;
    acc(1, a, d, c, h, r);
    chk(h == expect_hit, tag, h, expect_hit);
    if (h) begin ld_edge = c; ld_val = int'(d[15:0]); end
  endtask

  task automatic rd_chk(input logic [15:0] a, input string tag);
    int c; logic h; logic [31:0] r;
    acc(0, a, 32'h0, c, h, r);
    chk(h == 1'b1, {tag, " hit"}, h, 1);
    chk(r == 32'(expv(c)), tag, r, expv(c));
  endtask

  task automatic miss_chk(input bit we, input logic [15:0] a, input string tag);
    int c; logic h; logic [31:0] r;
    acc(we, a, 32'hFFFF_0777, c, h, r);
    chk(h == 1'b0 && r == 32'h0, tag, {h, r}, 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog act=1 exp=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #9 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(acc_hit_o == 0 && acc_rdata_o == 0, "R8 reset outputs", {acc_hit_o, acc_rdata_o}, 0);
    miss_chk(0, 16'h0000, "R8 disabled after reset");
    cfg(16'h0040, 1'b1);
    rd_chk(16'h0040, "R8 count zero");
    // upper write bits dropped, upper read bits zero
    wr(16'h0040, 32'hABCD_1234, 1, "R3 write hit");
    rd_chk(16'h0040, "R3 low half");
    // load at every prescaler phase, read at many offsets
    for (int ph = 0; ph < 8; ph++) begin
      while (((edge_n + 1) % 8) != ph) @(negedge clk_i);
      wr(16'h0040, 32'(16'h0100 + ph), 1, "R2 sweep write");
      for (int d = 0; d < 10; d++) rd_chk(16'h0040, "R1 R2 R9 sweep");
    end
    // wrong address
    wr(16'h0040, 32'h0000_0500, 1, "R4 write");
    miss_chk(1, 16'h0044, "R5 wrong address write");
    miss_chk(0, 16'h0041, "R5 wrong address read");
    rd_chk(16'h0040, "R5 count kept");
    // disabled: ignored writes, counting continues
    cfg(16'h0040, 1'b0);
    miss_chk(1, 16'h0040, "R5 disabled write");
    repeat (50) @(negedge clk_i);
    cfg(16'h0040, 1'b1);
    rd_chk(16'h0040, "R6 ran while disabled");
    // zero sticks
    wr(16'h0040, 32'h0000_0003, 1, "R7 write");
    repeat (40) @(negedge clk_i);
    rd_chk(16'h0040, "R7 holds zero");
    rd_chk(16'h0040, "R7 holds zero again");
    // relocate
    wr(16'h0040, 32'h0000_2000, 1, "R10 write");
    cfg(16'h1230, 1'b1);
    miss_chk(0, 16'h0040, "R10 old address");
    rd_chk(16'h1230, "R10 R4 new address");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule